// File: doc/BRIEF.md
# Serial Control Register with Staged Shutter Update

This block is the control port of an image sensor timing generator. A host shifts a 19-bit control word in over three wires: a serial clock, a serial data line and a strobe. All three are brought into the system clock domain through two-flop synchronisers. Edges are detected on the synchronised copies. Each rising serial clock edge shifts one data bit in. A rising strobe edge copies the assembled word into a holding register.

The fields of the held word reach their active registers in one of two ways. The four 2-bit phase selections (reset pulse, clamp, sample, feed-through) take effect one system clock after the strobe edge is detected. The shutter fields only change at the start of a horizontal line during which the readout pulse is active, so that a change lands cleanly on frame timing. The 2-bit shutter mode is applied at the first such line after a new word. The 9-bit shutter speed is applied at the next such line after that. After reset every active register is zero, which selects normal mode with the electronic shutter off.

Top module: `scr_ctrl`

## Requirements
- R1: Data is sampled on each rising edge of the synchronised serial clock. The first bit sent (D00) ends up as word bit 0 and the last bit (D18) as word bit 18, so bit i of the word is Di.
- R2: Only a rising strobe edge moves the shift register contents to the holding register. Shifting a new word without a strobe changes no output.
- R3: Field layout: the speed is D00..D08 with D00 as LSB. The mode is D09..D10 with D09 as LSB. The phases are reset D11..D12, clamp D13..D14, sample D15..D16 and feed-through D17..D18, each with its lower-numbered bit as LSB.
- R4: The phase outputs take a new word's values exactly four system clocks after the strobe input rises (two synchroniser flops, edge detect, then one update cycle), with no dependence on line timing.
- R5: After a new word is held, the mode output takes its mode field at the first line start with readout active, and not before.
- R6: The speed output takes the speed field at the next line start with readout active after the one that applied the mode. The mode and the speed never change in the same cycle.
- R7: A line start with readout inactive changes neither the mode nor the speed.
- R8: If a new strobe arrives while a speed update is pending, the speed applied is taken from the newest held word. That word's mode follows at the readout line after that.
- R9: After reset all outputs are zero. Serial clock and strobe held high, as an undriven pulled-up input reads, cause no shift and no latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Serial shift clock (asynchronous, idles high) |
| sdi_i | input | 1 | Serial data |
| stb_i | input | 1 | Strobe; rising edge latches the word (idles high) |
| line_start_i | input | 1 | One-cycle pulse at the start of each horizontal line |
| rdo_act_i | input | 1 | High during lines in which the readout pulse is active |
| spd_o | output | 9 | Active shutter speed |
| mode_o | output | 2 | Active shutter mode |
| ph_rst_o | output | 2 | Active reset-pulse phase select |
| ph_clp_o | output | 2 | Active clamp phase select |
| ph_smp_o | output | 2 | Active sample phase select |
| ph_ft_o | output | 2 | Active feed-through phase select |

## Verification
The assertions check on every cycle that the shift and holding registers move only after their detected edges. They also check that phases change only two cycles after a strobe edge, and that mode and speed change only after a readout line start. Mode and speed may never change together, and a line without readout must leave both unchanged. Only the bench scenarios can show the values themselves: the bit order and field layout of whole words, the four-clock strobe latency at the pins, the two-line staging sequence, the overwrite of a pending speed by a later word, and the quiet behaviour with the serial lines idling high.

// File: rtl/scr_pkg.sv
package scr_pkg;
  localparam int SPD_W   = 9;
  localparam int MODE_W  = 2;
  localparam int PH_W    = 2;
  localparam int NUM_PH  = 4;
  localparam int MODE_LSB = SPD_W;
  localparam int PH_LSB   = SPD_W + MODE_W;
  localparam int WORD_W   = PH_LSB + NUM_PH * PH_W;

  // phase field order inside the word
  localparam int PH_RST = 0;
  localparam int PH_CLP = 1;
  localparam int PH_SMP = 2;
  localparam int PH_FT  = 3;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [PH_W-1:0]   ph_t;
endpackage

// File: rtl/scr_sync.sv
module scr_sync #(
  parameter int            W       = 1,
  parameter int            STAGES  = 2,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[g] <= RST_VAL;
      else if (g == 0) chain_q[g] <= d_i;
      else chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/scr_shift.sv
module scr_shift
  import scr_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  sck_s_i,
  input  logic  sdi_s_i,
  input  logic  stb_s_i,
  output word_t hold_o,
  output logic  load_o
);
  logic  sck_q, stb_q, load_q;
  word_t sh_q, hold_q;
  logic  sck_rise, stb_rise;

  assign sck_rise = sck_s_i & ~sck_q;
  assign stb_rise = stb_s_i & ~stb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q  <= 1'b1;
      stb_q  <= 1'b1;
      sh_q   <= '0;
      hold_q <= '0;
      load_q <= 1'b0;
    end else begin
      sck_q  <= sck_s_i;
      stb_q  <= stb_s_i;
      load_q <= stb_rise;
      // first bit sent drifts down to bit 0
      if (sck_rise) sh_q <= {sdi_s_i, sh_q[WORD_W-1:1]};
      if (stb_rise) hold_q <= sh_q;
    end
  end

  assign hold_o = hold_q;
  assign load_o = load_q;

  p_shift_on_sck_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sh_q) |-> $past(sck_rise));
  p_hold_on_stb_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(hold_q) |-> $past(stb_rise));
endmodule

// File: rtl/scr_stage.sv
module scr_stage
  import scr_pkg::*;
(
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  word_t                       hold_i,
  input  logic                        load_i,
  input  logic                        line_i,
  input  logic                        rdo_i,
  output logic [SPD_W-1:0]            spd_o,
  output logic [MODE_W-1:0]           mode_o,
  output logic [NUM_PH-1:0][PH_W-1:0] ph_o
);
  logic [SPD_W-1:0]            spd_q;
  logic [MODE_W-1:0]           mode_q;
  logic [NUM_PH-1:0][PH_W-1:0] ph_q, ph_nx;
  logic                        word_new_q, spd_pend_q, line_hit;

  for (genvar g = 0; g < NUM_PH; g++) begin : g_ph
    assign ph_nx[g] = hold_i[PH_LSB + g*PH_W +: PH_W];
  end

  assign line_hit = line_i & rdo_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q       <= '0;
      mode_q     <= '0;
      spd_q      <= '0;
      word_new_q <= 1'b0;
      spd_pend_q <= 1'b0;
    end else begin
      if (line_hit) begin
        if (spd_pend_q) begin
          spd_q      <= hold_i[SPD_W-1:0];
          spd_pend_q <= 1'b0;
        end else if (word_new_q) begin
          mode_q     <= hold_i[MODE_LSB +: MODE_W];
          spd_pend_q <= 1'b1;
          word_new_q <= 1'b0;
        end
      end
      // a fresh word wins over a same-cycle clear
      if (load_i) begin
        ph_q       <= ph_nx;
        word_new_q <= 1'b1;
      end
    end
  end

  assign spd_o  = spd_q;
  assign mode_o = mode_q;
  assign ph_o   = ph_q;

  p_phase_on_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ph_q) |-> $past(load_i));
  p_mode_on_line_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mode_q) |-> $past(line_i && rdo_i));
  p_spd_on_line_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(spd_q) |-> $past(line_i && rdo_i));
  p_not_together_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!$stable(mode_q) && !$stable(spd_q)));
  p_pend_after_mode_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mode_q) |-> spd_pend_q);
  p_no_rdo_no_change_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_i && !rdo_i) |=> ($stable(mode_q) && $stable(spd_q)));
endmodule

// File: rtl/scr_ctrl.sv
module scr_ctrl
  import scr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              sdi_i,
  input  logic              stb_i,
  input  logic              line_start_i,
  input  logic              rdo_act_i,
  output logic [SPD_W-1:0]  spd_o,
  output logic [MODE_W-1:0] mode_o,
  output logic [PH_W-1:0]   ph_rst_o,
  output logic [PH_W-1:0]   ph_clp_o,
  output logic [PH_W-1:0]   ph_smp_o,
  output logic [PH_W-1:0]   ph_ft_o
);
  logic [2:0]                  ser_s;
  word_t                       hold;
  logic                        load;
  logic [NUM_PH-1:0][PH_W-1:0] ph;

  // {stb, sdi, sck}; pulled-up lines reset high to avoid a false edge
  scr_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b101)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({stb_i, sdi_i, sck_i}),
    .q_o    (ser_s)
  );

  scr_shift u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sck_s_i (ser_s[0]),
    .sdi_s_i (ser_s[1]),
    .stb_s_i (ser_s[2]),
    .hold_o  (hold),
    .load_o  (load)
  );

  scr_stage u_stage (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hold_i (hold),
    .load_i (load),
    .line_i (line_start_i),
    .rdo_i  (rdo_act_i),
    .spd_o  (spd_o),
    .mode_o (mode_o),
    .ph_o   (ph)
  );

  assign ph_rst_o = ph[PH_RST];
  assign ph_clp_o = ph[PH_CLP];
  assign ph_smp_o = ph[PH_SMP];
  assign ph_ft_o  = ph[PH_FT];
endmodule

// File: tb/tb_scr_ctrl.sv
module tb_scr_ctrl;
  logic clk = 1'b0;
  logic rst_n, sck, sdi, stb, line, rdo;
  logic [8:0] spd;
  logic [1:0] mode, p_rst, p_clp, p_smp, p_ft;
  int n_chk = 0, n_fail = 0;
  logic [8:0] e_spd;
  logic [1:0] e_mode;

  always #5 clk = ~clk;

  scr_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .sdi_i(sdi), .stb_i(stb),
    .line_start_i(line), .rdo_act_i(rdo), .spd_o(spd), .mode_o(mode),
    .ph_rst_o(p_rst), .ph_clp_o(p_clp), .ph_smp_o(p_smp), .ph_ft_o(p_ft)
  );

  localparam int NV = 6;
  localparam logic [18:0] VEC [NV] = '{
    19'h7FFFF, 19'h00001, 19'h40000, 19'h00200, 19'h2AAAA, 19'h15555
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_word(input logic [18:0] w);
    for (int i = 0; i < 19; i++) begin
      @(negedge clk); sck = 1'b0; sdi = w[i];
      repeat (3) @(negedge clk);
      sck = 1'b1;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic strobe();
    @(negedge clk); stb = 1'b0;
    repeat (4) @(negedge clk);
    stb = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic pulse_line(input logic r);
    @(negedge clk); line = 1'b1; rdo = r;
    @(negedge clk); line = 1'b0; rdo = 1'b0;
  endtask

  task automatic chk_ph(input string req, input logic [18:0] w);
    chk(req, {p_ft, p_smp, p_clp, p_rst}, {24'd0, w[18:11]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sck = 1'b1; stb = 1'b1; sdi = 1'b0; line = 1'b0; rdo = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R9 reset state, then idle-high lines and readout lines with no word
    chk("R9 reset", {spd, mode, p_rst, p_clp, p_smp, p_ft}, 0);
    repeat (20) @(negedge clk);
    pulse_line(1'b1); pulse_line(1'b1);
    chk("R9 idle high", {spd, mode, p_rst, p_clp, p_smp, p_ft}, 0);
    e_spd = '0; e_mode = '0;

    // table walk: R1 bit order, R3 layout, R5/R6 staging, R7 gating
    for (int v = 0; v < NV; v++) begin
      send_word(VEC[v]);
      strobe();
      chk_ph("R3 phases", VEC[v]);
      chk("R5 mode before line", mode, e_mode);
      chk("R6 speed before line", spd, e_spd);
      pulse_line(1'b0);
      chk("R7 mode no rdo", mode, e_mode);
      chk("R7 speed no rdo", spd, e_spd);
      pulse_line(1'b1);
      e_mode = VEC[v][10:9];
      chk("R5 mode applied", mode, e_mode);
      chk("R6 speed held", spd, e_spd);
      pulse_line(1'b1);
      e_spd = VEC[v][8:0];
      chk("R1 R3 speed applied", spd, e_spd);
      chk("R6 mode kept", mode, e_mode);
    end

    // R4 exact strobe latency
    send_word(19'h0F0F0);
    @(negedge clk); stb = 1'b0;
    repeat (4) @(negedge clk);
    stb = 1'b1;
    repeat (3) @(negedge clk);
    chk_ph("R4 phases before 4th clock", VEC[NV-1]);
    @(negedge clk);
    chk_ph("R4 phases at 4th clock", 19'h0F0F0);
    repeat (4) @(negedge clk);
    pulse_line(1'b1); pulse_line(1'b1);
    e_mode = 2'(19'h0F0F0 >> 9); e_spd = 9'(19'h0F0F0);
    chk("R5 R6 latency word fields", {spd, mode}, {e_spd, e_mode});

    // R2 shift without strobe
    send_word(19'h5A5A5);
    repeat (6) @(negedge clk);
    chk_ph("R2 no strobe phases", 19'h0F0F0);
    pulse_line(1'b1); pulse_line(1'b1);
    chk("R2 no strobe shutter", {spd, mode}, {e_spd, e_mode});

    // R8 new word during pending speed
    send_word(19'h12345);
    strobe();
    pulse_line(1'b1);
    chk("R8 mode A", mode, 2'(19'h12345 >> 9));
    send_word(19'h6BCDE);
    strobe();
    chk_ph("R8 phases B", 19'h6BCDE);
    pulse_line(1'b1);
    chk("R8 speed from B", spd, 9'(19'h6BCDE));
    chk("R8 mode still A", mode, 2'(19'h12345 >> 9));
    pulse_line(1'b1);
    chk("R8 mode B", mode, 2'(19'h6BCDE >> 9));

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule